// File: doc/BRIEF.md
# Sweep Trigger Selector with Video Gate Generator

This block decides when a sweep may start and when video gating is open. A 2-bit select chooses one of four trigger inputs: a free-running tick from the converter clock, a video comparator bit, a mains line-sync bit or an external TTL bit. The first rising edge of the chosen input sets a sticky scan flag. That flag stays high until the sweep engine pulses an end-of-sweep input.

The same external TTL input also drives a gate generator, which has two modes. In level mode the gate follows the synchronized input, with an optional inversion. In edge mode a selected edge (rising or falling) starts a programmable delay interval. A programmable open interval follows the delay, and the gate is high only during that open interval. All timing is counted in cycles of the block clock.

Top module: `sweep_trig_gate`

## Requirements
- R1: `src_sel` chooses the trigger source as follows: 2'b00 = free tick, 2'b01 = video, 2'b11 = line, 2'b10 = external. The bit order is {bit1, bit0}. Edges on sources that are not selected do not affect `scan_armed`.
- R2: Every asynchronous input passes through two flip-flops. If the selected source is first sampled high at clock edge k, `scan_armed` is high after edge k+2 and not after edge k+1.
- R3: The internal trigger event that a rising edge of the selected source produces lasts exactly one clock cycle.
- R4: Once set, `scan_armed` stays high until `sweep_done` is sampled high. Later trigger edges leave it unchanged.
- R5: `sweep_done` sampled high at an edge clears `scan_armed` after that edge. This clear wins over a trigger that arrives in the same cycle.
- R6: In level mode (`gate_edge_mode` = 0), `gate_out` equals the synchronized `ext_in` XOR `gate_fall`. If `ext_in` changes before edge k, `gate_out` shows the change after edge k+1.
- R7: In edge mode, `gate_fall` = 0 selects the rising edge of `ext_in` and `gate_fall` = 1 selects the falling edge. The opposite edge starts nothing. Between gate pulses, `gate_out` is low.
- R8: In edge mode, if the selected edge is first sampled at edge k, `gate_out` goes high after edge k+2+`gate_delay`. It stays high for exactly `gate_len` cycles.
- R9: A `gate_delay` of zero opens the gate after edge k+2, which is the cycle right after the edge is detected. A `gate_len` of zero gives no gate pulse.
- R10: An edge of `ext_in` that occurs while a delay or open interval is running is ignored. It neither restarts nor extends the gate.
- R11: Reset clears `scan_armed`, the synchronizers and the gate sequencer. In edge mode `gate_out` is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 2 | Trigger source select |
| free_tick | input | 1 | Free-run tick derived from converter clock |
| video_in | input | 1 | Video comparator output |
| line_in | input | 1 | Mains line-sync bit |
| ext_in | input | 1 | External TTL trigger / gate input |
| sweep_done | input | 1 | End-of-sweep pulse, clears the scan flag |
| gate_edge_mode | input | 1 | 0 = level gating, 1 = edge gating |
| gate_fall | input | 1 | Polarity: inverts level gate, selects falling edge |
| gate_delay | input | CNT_W | Delay interval in cycles |
| gate_len | input | CNT_W | Open interval in cycles |
| scan_armed | output | 1 | Sticky sweep-start flag |
| gate_out | output | 1 | Video gate |

## Verification
The assertions assume that `gate_delay`, `gate_len` and the mode inputs are held stable while a gate sequence is running. They also assume that `src_sel` does not change close to an edge of a source. A change of select can make the muxed level look like a fresh rising edge. The bench follows both assumptions: it changes configuration only while all sources are low and the gate sequencer is idle, and it leaves several settling cycles before each scenario. All asynchronous inputs are driven on the falling clock edge.

// File: rtl/sweep_trig_gate.sv
module sweep_trig_gate #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       src_sel,
  input  logic             free_tick,
  input  logic             video_in,
  input  logic             line_in,
  input  logic             ext_in,
  input  logic             sweep_done,
  input  logic             gate_edge_mode,
  input  logic             gate_fall,
  input  logic [CNT_W-1:0] gate_delay,
  input  logic [CNT_W-1:0] gate_len,
  output logic             scan_armed,
  output logic             gate_out
);

  localparam int NSRC = 4;
  localparam int EXT  = 3;

  typedef enum logic [1:0] {G_IDLE, G_DELAY, G_OPEN} gstate_t;

  logic [NSRC-1:0] raw, sy1, sy2;
  logic            sel_lvl, sel_prev, trig;
  logic            ext_prev, ext_ev;
  gstate_t         gst;
  logic [CNT_W-1:0] gcnt;

  assign raw = {ext_in, line_in, video_in, free_tick};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
    end else begin
      sy1 <= raw;
      sy2 <= sy1;
    end
  end

  always_comb begin
    case (src_sel)
      2'b00:   sel_lvl = sy2[0];
      2'b01:   sel_lvl = sy2[1];
      2'b11:   sel_lvl = sy2[2];
      default: sel_lvl = sy2[EXT];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_prev <= 1'b0;
      ext_prev <= 1'b0;
    end else begin
      sel_prev <= sel_lvl;
      ext_prev <= sy2[EXT];
    end
  end

  assign trig   = sel_lvl & ~sel_prev;
  assign ext_ev = gate_fall ? (ext_prev & ~sy2[EXT]) : (sy2[EXT] & ~ext_prev);

  always_ff @(posedge clk) begin
    if (!rst_n)          scan_armed <= 1'b0;
    else if (sweep_done) scan_armed <= 1'b0;
    else if (trig)       scan_armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !gate_edge_mode) begin
      gst  <= G_IDLE;
      gcnt <= '0;
    end else begin
      case (gst)
        G_IDLE: begin
          if (ext_ev && gate_len != '0) begin
            if (gate_delay == '0) begin
              gst  <= G_OPEN;
              gcnt <= gate_len;
            end else begin
              gst  <= G_DELAY;
              gcnt <= gate_delay;
            end
          end
        end
        G_DELAY: begin
          if (gcnt <= 1) begin
            gst  <= G_OPEN;
            gcnt <= gate_len;
          end else begin
            gcnt <= gcnt - 1'b1;
          end
        end
        G_OPEN: begin
          if (gcnt <= 1) begin
            gst  <= G_IDLE;
            gcnt <= '0;
          end else begin
            gcnt <= gcnt - 1'b1;
          end
        end
        default: begin
          gst  <= G_IDLE;
          gcnt <= '0;
        end
      endcase
    end
  end

  assign gate_out = gate_edge_mode ? (gst == G_OPEN) : (sy2[EXT] ^ gate_fall);

  AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig); // R3

  AST_SCAN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_armed && !sweep_done) |=> scan_armed); // R4

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |=> !scan_armed); // R5

  AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_edge_mode && gst == G_IDLE && gate_len == '0) |=> gst == G_IDLE); // R9

  AST_DELAY_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_edge_mode && gst == G_DELAY && gcnt > 1)
      |=> (gst == G_DELAY && gcnt == CNT_W'($past(gcnt) - 1'b1))); // R10

  AST_OPEN_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_edge_mode && gst == G_OPEN && gcnt > 1)
      |=> (gst == G_OPEN && gcnt == CNT_W'($past(gcnt) - 1'b1))); // R8

  AST_LEVEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_edge_mode |=> gst == G_IDLE); // R6

endmodule

// File: tb/sweep_trig_gate_tb.sv
module sweep_trig_gate_tb;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic free_tick = 0, video_in = 0, line_in = 0, ext_in = 0, sweep_done = 0;
  logic gate_edge_mode = 0, gate_fall = 0;
  logic [CNT_W-1:0] gate_delay = '0, gate_len = '0;
  logic scan_armed, gate_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sweep_trig_gate #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .free_tick(free_tick),
    .video_in(video_in), .line_in(line_in), .ext_in(ext_in),
    .sweep_done(sweep_done), .gate_edge_mode(gate_edge_mode),
    .gate_fall(gate_fall), .gate_delay(gate_delay), .gate_len(gate_len),
    .scan_armed(scan_armed), .gate_out(gate_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic clear_scan();
    @(negedge clk); sweep_done = 1;
    @(negedge clk); sweep_done = 0;
    edges(1);
  endtask

  task automatic set_src(input int s, input logic v);
    case (s)
      0: free_tick = v;
      1: video_in = v;
      2: line_in = v;
      default: ext_in = v;
    endcase
  endtask

  task automatic measure(input int win, output int first, output int cnt);
    first = -1; cnt = 0;
    for (int i = 1; i <= win; i++) begin
      @(posedge clk); #1;
      if (gate_out) begin
        if (first < 0) first = i;
        cnt++;
      end
    end
  endtask

  task automatic t_reset();
    chk(scan_armed == 0, "R11 scan after reset", scan_armed, 0);
    gate_edge_mode = 1; edges(1);
    chk(gate_out == 0, "R11 gate after reset", gate_out, 0);
    gate_edge_mode = 0;
  endtask

  task automatic t_source(input logic [1:0] sel, input int idx, input string name);
    src_sel = sel; edges(4); clear_scan();
    @(negedge clk); set_src(idx, 1);
    edges(2);
    chk(scan_armed == 0, {"R2 latency ", name}, scan_armed, 0);
    edges(1);
    chk(scan_armed == 1, {"R1 ", name, " sets scan"}, scan_armed, 1);
    @(negedge clk); set_src(idx, 0); edges(4);
    chk(scan_armed == 1, {"R4 sticky ", name}, scan_armed, 1);
    clear_scan();
    chk(scan_armed == 0, {"R5 clear ", name}, scan_armed, 0);
  endtask

  task automatic t_unselected();
    src_sel = 2'b01; edges(4); clear_scan();
    @(negedge clk); line_in = 1; ext_in = 1; free_tick = 1;
    edges(5);
    chk(scan_armed == 0, "R1 unselected ignored", scan_armed, 0);
    @(negedge clk); line_in = 0; ext_in = 0; free_tick = 0; edges(4);
  endtask

  task automatic t_sticky_retrigger();
    src_sel = 2'b11; edges(4); clear_scan();
    for (int p = 0; p < 3; p++) begin
      @(negedge clk); line_in = 1; edges(3);
      @(negedge clk); line_in = 0; edges(2);
    end
    chk(scan_armed == 1, "R4 retrigger keeps set", scan_armed, 1);
    clear_scan();
  endtask

  task automatic t_clear_priority();
    src_sel = 2'b01; edges(4); clear_scan();
    @(negedge clk); video_in = 1;
    @(posedge clk);
    @(negedge clk);
    @(negedge clk); sweep_done = 1;
    @(negedge clk); sweep_done = 0;
    #0;
    chk(scan_armed == 0, "R5 clear beats trigger", scan_armed, 0);
    edges(4);
    chk(scan_armed == 0, "R5 no late trigger", scan_armed, 0);
    @(negedge clk); video_in = 0; edges(4);
  endtask

  task automatic t_level(input logic fall);
    int v1, v2;
    gate_edge_mode = 0; gate_fall = fall; ext_in = 0; edges(4);
    chk(gate_out == fall, "R6 level idle", gate_out, fall);
    @(negedge clk); ext_in = 1;
    edges(1); v1 = gate_out;
    edges(1); v2 = gate_out;
    chk(v1 == int'(fall), "R6 level latency", v1, fall);
    chk(v2 == int'(!fall), "R6 level follows", v2, !fall);
    @(negedge clk); ext_in = 0; edges(4);
  endtask

  task automatic t_edge(input logic fall, input int d, input int l, input string tag);
    int first, cnt, ef;
    gate_edge_mode = 1; gate_fall = fall; gate_delay = d[CNT_W-1:0]; gate_len = l[CNT_W-1:0];
    ext_in = fall; edges(6);
    chk(gate_out == 0, {tag, " idle low"}, gate_out, 0);
    @(negedge clk); ext_in = !fall;
    measure(d + l + 8, first, cnt);
    ef = (l == 0) ? -1 : 3 + d;
    chk(first == ef, {tag, " open cycle"}, first, ef);
    chk(cnt == l, {tag, " open length"}, cnt, l);
    @(negedge clk); ext_in = fall;
    measure(d + l + 8, first, cnt);
    chk(cnt == 0, "R7 opposite edge no gate", cnt, 0);
  endtask

  task automatic t_busy_ignore();
    int first, cnt;
    gate_edge_mode = 1; gate_fall = 0; gate_delay = 3; gate_len = 4;
    ext_in = 0; edges(6);
    @(negedge clk); ext_in = 1;
    fork
      measure(20, first, cnt);
      begin
        edges(1); @(negedge clk); ext_in = 0;
        edges(1); @(negedge clk); ext_in = 1;
        edges(3); @(negedge clk); ext_in = 0;
        edges(1); @(negedge clk); ext_in = 1;
      end
    join
    chk(first == 6, "R10 busy edge start", first, 6);
    chk(cnt == 4, "R10 busy edge length", cnt, 4);
    @(negedge clk); ext_in = 0; edges(6);
  endtask

  initial begin
    edges(3);
    @(negedge clk); rst_n = 1;
    edges(1);
    t_reset();
    t_source(2'b00, 0, "free");
    t_source(2'b01, 1, "video");
    t_source(2'b11, 2, "line");
    t_source(2'b10, 3, "external");
    t_unselected();
    t_sticky_retrigger();
    t_clear_priority();
    t_level(0);
    t_level(1);
    t_edge(0, 2, 3, "R8 rise");
    t_edge(1, 4, 2, "R7 fall");
    t_edge(0, 0, 3, "R9 zero delay");
    t_edge(0, 2, 0, "R9 zero length");
    t_busy_ignore();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule